// File: doc/BRIEF.md
# Injected-Instruction Launcher for a DMA Manager

This block is the front end that lets software push a single instruction straight into a DMA manager without any program fetch. Software writes the instruction bytes and a thread-select field into two write-only staging words. It then writes zero to a command word. The block decodes the staged instruction and runs it either as the manager thread or against one selected channel thread.

On the manager thread two instructions are honoured: a no-operation and a channel launch. A launch names a channel, a 32-bit start address and a security flavour. The block drives a start request, the start address and a non-secure flag to that channel sequencer, and it holds the request until the sequencer acknowledges it. While an instruction is in flight the block reports busy, and it ignores further commands. A failed launch or an instruction it cannot decode leaves a sticky record in two fault registers, which only reset clears.

Top module: `dbg_launch_top`

Register word offsets: 0x00 status (bit 0 busy, read-only), 0x04 command (write-only), 0x08 staging word 0 (write-only), 0x0C staging word 1 (write-only), 0x10 fault flag (bit 0, read-only), 0x14 fault type (read-only). Unused or write-only offsets read as zero. Reads are combinational on the address.

## Requirements
- R1: After reset, status, fault flag and fault type all read 0, and no channel start is asserted.
- R2: Staging word 0 has the thread select in bit 0 (1 selects a channel thread, 0 selects the manager), the channel number in bits 15:8, instruction byte 0 in bits 23:16 and byte 1 in bits 31:24. Staging word 1 holds bytes 2 to 5, with byte 2 in bits 7:0.
- R3: A write of 0 to the command word executes the staged instruction. A write of any other value has no effect.
- R4: On the manager thread, a byte 0 of 0xA0 (secure) or 0xA2 (non-secure, bit 1 set) launches the channel named by byte 1. The start address is bytes 2 to 5. The one-hot start for that channel stays high, with a stable address and flag, until that channel's acknowledge is sampled.
- R5: Busy reads 1 from the first cycle after an accepted command until the cycle after the acknowledge. Command writes while busy are ignored.
- R6: A manager instruction with byte 0 equal to 0x18 is a no-op. It raises no fault and no start, and busy is high for exactly one cycle.
- R7: A launch to a channel whose stopped input is low asserts no start. It sets fault-type bit 4 and fault-flag bit 0.
- R8: A manager launch naming channel 8 or higher, and any other manager opcode, sets fault-type bit 0 and fault-flag bit 0, with no start.
- R9: On a channel thread, a channel field of 8 or higher sets fault-type bit 0. A 0x18 no-op on a valid channel does nothing. Any other opcode, including a launch, sets fault-type bit 0.
- R10: Fault bits accumulate and stay set through later successful instructions until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ch_stopped | input | 8 | Per-channel stopped indication |
| ch_ack | input | 8 | Per-channel start acknowledge |
| ch_start | output | 8 | One-hot channel start request |
| ch_start_pc | output | 32 | Start address for the launched channel |
| ch_nonsecure | output | 1 | Launch is non-secure |

## Verification
A command write sampled at clock edge N makes busy visible after edge N. A launch raises the start request after edge N+1. Fault bits update after edge N+1, and busy drops after the edge that samples the acknowledge. The bench drives every input on the falling edge and reads status at the next falling edge after each of those points, so each sample lands one half-cycle after the register that produces it. A scoreboard queue holds the expected launches. The monitor compares every start request it sees against the queue, checks that the request stays steady for a chosen acknowledge delay, and flags any start it did not expect.

// File: rtl/dl_pkg.sv
package dl_pkg;
    localparam int WORD_W = 32;

    localparam logic [7:0] OFS_STATUS = 8'h00;
    localparam logic [7:0] OFS_CMD    = 8'h04;
    localparam logic [7:0] OFS_STAGE0 = 8'h08;
    localparam logic [7:0] OFS_STAGE1 = 8'h0C;
    localparam logic [7:0] OFS_FFLAG  = 8'h10;
    localparam logic [7:0] OFS_FTYPE  = 8'h14;

    localparam logic [7:0] OP_LAUNCH  = 8'hA0;
    localparam logic [7:0] OP_NOP     = 8'h18;
    localparam logic [7:0] NS_MASK    = 8'h02;

    localparam int FT_UNDEF_BIT  = 0;
    localparam int FT_LAUNCH_BIT = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WAIT} dl_state_e;
    typedef enum logic [1:0] {ACT_NONE, ACT_LAUNCH, ACT_UNDEF, ACT_LERR} dl_action_e;

    typedef struct packed {
        logic        to_chan;
        logic [7:0]  chan_sel;
        logic [7:0]  op;
        logic [7:0]  arg;
        logic [31:0] tail;
    } dl_instr_t;

    typedef struct packed {
        dl_action_e  act;
        logic [7:0]  chan;
        logic [31:0] pc;
        logic        ns;
    } dl_decode_t;

    function automatic dl_instr_t unpack_stage(input logic [31:0] s0, input logic [31:0] s1);
        dl_instr_t r;
        r.to_chan  = s0[0];
        r.chan_sel = s0[15:8];
        r.op       = s0[23:16];
        r.arg      = s0[31:24];
        r.tail     = s1;
        return r;
    endfunction

    function automatic logic is_launch(input logic [7:0] op);
        return (op & ~NS_MASK) == OP_LAUNCH;
    endfunction
endpackage

// File: rtl/dl_stage.sv
module dl_stage
    import dl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr0,
    input  logic        wr1,
    input  logic [31:0] wdata,
    output dl_instr_t   instr
);
    logic [31:0] stage0_q, stage1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage0_q <= '0;
            stage1_q <= '0;
        end else begin
            if (wr0) stage0_q <= wdata;
            if (wr1) stage1_q <= wdata;
        end
    end

    assign instr = unpack_stage(stage0_q, stage1_q);
endmodule

// File: rtl/dl_decode.sv
module dl_decode
    import dl_pkg::*;
#(
    parameter int NCH = 8
) (
    input  dl_instr_t        instr,
    input  logic [NCH-1:0]   ch_stopped,
    output dl_decode_t       dec
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [7:0] NCH_B = 8'(NCH);

    logic target_ok;
    logic target_stopped;

    assign target_ok      = instr.arg < NCH_B;
    assign target_stopped = ch_stopped[instr.arg[CH_W-1:0]];

    always_comb begin
        dec.chan = instr.arg;
        dec.pc   = instr.tail;
        dec.ns   = |(instr.op & NS_MASK);
        dec.act  = ACT_UNDEF;
        if (instr.to_chan) begin
            if (instr.chan_sel < NCH_B && instr.op == OP_NOP)
                dec.act = ACT_NONE;
        end else if (instr.op == OP_NOP) begin
            dec.act = ACT_NONE;
        end else if (is_launch(instr.op)) begin
            if (!target_ok)           dec.act = ACT_UNDEF;
            else if (!target_stopped) dec.act = ACT_LERR;
            else                      dec.act = ACT_LAUNCH;
        end
    end
endmodule

// File: rtl/dl_ctrl.sv
module dl_ctrl
    import dl_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_go,
    input  dl_decode_t       dec,
    input  logic [NCH-1:0]   ch_ack,
    output logic             busy,
    output logic [NCH-1:0]   ch_start,
    output logic [31:0]      ch_start_pc,
    output logic             ch_nonsecure,
    output logic             fault_flag,
    output logic [31:0]      fault_type
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    dl_state_e       state_q;
    logic [CH_W-1:0] chan_q;
    logic [31:0]     pc_q;
    logic            ns_q;
    logic            fflag_q;
    logic [31:0]     ftype_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
            pc_q    <= '0;
            ns_q    <= 1'b0;
            fflag_q <= 1'b0;
            ftype_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cmd_go) state_q <= ST_EXEC;
                ST_EXEC: begin
                    state_q <= ST_IDLE;
                    case (dec.act)
                        ACT_LAUNCH: begin
                            state_q <= ST_WAIT;
                            chan_q  <= dec.chan[CH_W-1:0];
                            pc_q    <= dec.pc;
                            ns_q    <= dec.ns;
                        end
                        ACT_UNDEF: begin
                            fflag_q               <= 1'b1;
                            ftype_q[FT_UNDEF_BIT] <= 1'b1;
                        end
                        ACT_LERR: begin
                            fflag_q                <= 1'b1;
                            ftype_q[FT_LAUNCH_BIT] <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_WAIT: if (ch_ack[chan_q]) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = state_q != ST_IDLE;
    assign ch_start     = (state_q == ST_WAIT) ? (NCH'(1) << chan_q) : '0;
    assign ch_start_pc  = pc_q;
    assign ch_nonsecure = ns_q;
    assign fault_flag   = fflag_q;
    assign fault_type   = ftype_q;

    // R4: at most one channel is asked to start
    a_r4_start_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_start));
    // R4: an unacknowledged start holds with its address and flag
    a_r4_start_held: assert property (@(posedge clk) disable iff (rst)
        (|(ch_start & ~ch_ack)) |=> (ch_start == $past(ch_start)) && $stable(ch_start_pc) && $stable(ch_nonsecure));
    // R5: a start request is only visible while busy
    a_r5_busy_with_start: assert property (@(posedge clk) disable iff (rst)
        (|ch_start) |-> busy);
    // R5: a command accepted from idle makes the block busy
    a_r5_cmd_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && !busy) |=> busy);
    // R10: fault bits never clear outside reset
    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fault_type & $past(fault_type)) == $past(fault_type)) && (fault_flag || !$past(fault_flag)));
endmodule

// File: rtl/dbg_launch_top.sv
module dbg_launch_top
    import dl_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    ch_stopped,
    input  logic [NCH-1:0]    ch_ack,
    output logic [NCH-1:0]    ch_start,
    output logic [31:0]       ch_start_pc,
    output logic              ch_nonsecure
);
    dl_instr_t   instr;
    dl_decode_t  dec;
    logic        busy;
    logic        fault_flag;
    logic [31:0] fault_type;
    logic        wr_s0, wr_s1, cmd_go;

    assign wr_s0  = bus_wr && bus_addr == ADDR_W'(OFS_STAGE0);
    assign wr_s1  = bus_wr && bus_addr == ADDR_W'(OFS_STAGE1);
    assign cmd_go = bus_wr && bus_addr == ADDR_W'(OFS_CMD) && bus_wdata == '0;

    dl_stage u_stage (
        .clk(clk), .rst(rst), .wr0(wr_s0), .wr1(wr_s1),
        .wdata(bus_wdata), .instr(instr)
    );

    dl_decode #(.NCH(NCH)) u_decode (
        .instr(instr), .ch_stopped(ch_stopped), .dec(dec)
    );

    dl_ctrl #(.NCH(NCH)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .dec(dec), .ch_ack(ch_ack),
        .busy(busy), .ch_start(ch_start), .ch_start_pc(ch_start_pc),
        .ch_nonsecure(ch_nonsecure), .fault_flag(fault_flag), .fault_type(fault_type)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_STATUS))     bus_rdata = {31'b0, busy};
        else if (bus_addr == ADDR_W'(OFS_FFLAG)) bus_rdata = {31'b0, fault_flag};
        else if (bus_addr == ADDR_W'(OFS_FTYPE)) bus_rdata = fault_type;
    end
endmodule

// File: tb/tb_dbg_launch_top.sv
module tb_dbg_launch_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [7:0]  ch_stopped = 8'hFF;
    logic [7:0]  ch_ack = 0;
    logic [7:0]  ch_start;
    logic [31:0] ch_start_pc;
    logic        ch_nonsecure;

    int tests = 0, fails = 0;
    int ack_delay = 1;
    bit finished = 0;

    typedef struct {int ch; logic [31:0] pc; logic ns;} exp_t;
    exp_t exp_q[$];

    dbg_launch_top dut (.*);

    always #10 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_now(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            rd_now(8'h00, s);
            if (s[0] == 0) break;
        end
    endtask

    task automatic stage(logic [31:0] s0, logic [31:0] s1);
        wr(8'h08, s0);
        wr(8'h0C, s1);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Monitor: compare each start with the scoreboard, then acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (ch_start != 0) begin
                logic [7:0] held;
                held = ch_start;
                if (exp_q.size() == 0) begin
                    chk("R7/R8 unexpected start", {24'b0, ch_start}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk("R4 start channel", {24'b0, ch_start}, 32'(8'(1) << e.ch));
                    chk("R2/R4 start pc", ch_start_pc, e.pc);
                    chk("R4 nonsecure", {31'b0, ch_nonsecure}, {31'b0, e.ns});
                end
                for (int k = 0; k < ack_delay; k++) begin
                    @(negedge clk);
                    chk("R4 start held", {24'b0, ch_start}, {24'b0, held});
                end
                ch_ack = held;
                @(negedge clk);
                ch_ack = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd_now(8'h00, d); chk("R1 status", d, 0);
        rd_now(8'h10, d); chk("R1 fault flag", d, 0);
        rd_now(8'h14, d); chk("R1 fault type", d, 0);
        chk("R1 no start", {24'b0, ch_start}, 0);

        // R4/R2 secure launch of channel 3
        stage(32'h03A0_0000, 32'h1234_5678);
        exp_q.push_back('{3, 32'h1234_5678, 1'b0});
        wr(8'h04, 0);
        rd_now(8'h00, d); chk("R5 busy after cmd", d, 1);
        wait_idle();
        rd_now(8'h14, d); chk("R4 launch no fault", d, 0);

        // R5: non-secure launch of channel 7 with slow acknowledge; commands during busy ignored
        ack_delay = 6;
        stage(32'h07A2_0000, 32'hDEAD_BEEF);
        exp_q.push_back('{7, 32'hDEAD_BEEF, 1'b1});
        wr(8'h04, 0);
        wr(8'h08, 32'h00FF_0000);
        wr(8'h04, 0);
        rd_now(8'h00, d); chk("R5 still busy", d, 1);
        wait_idle();
        ack_delay = 1;
        repeat (2) @(negedge clk);
        rd_now(8'h14, d); chk("R5 busy command ignored", d, 0);

        // R3: nonzero command ignored (undefined opcode 0xFF is staged)
        wr(8'h04, 1);
        rd_now(8'h00, d); chk("R3 nonzero cmd no busy", d, 0);
        repeat (2) @(negedge clk);
        rd_now(8'h14, d); chk("R3 nonzero cmd no fault", d, 0);

        // R6: manager no-op, busy exactly one cycle
        stage(32'h0018_0000, 0);
        wr(8'h04, 0);
        rd_now(8'h00, d); chk("R6 nop busy", d, 1);
        @(negedge clk);
        rd_now(8'h00, d); chk("R6 nop one cycle", d, 0);
        rd_now(8'h14, d); chk("R6 nop no fault", d, 0);

        // R9: channel-thread no-op on channel 2
        stage(32'h0018_0201, 0);
        wr(8'h04, 0);
        wait_idle();
        rd_now(8'h14, d); chk("R9 chan nop no fault", d, 0);

        // R8: launch naming channel 9
        stage(32'h09A0_0000, 32'h0000_1000);
        wr(8'h04, 0);
        wait_idle();
        rd_now(8'h14, d); chk("R8 bad channel", d, 32'h01);
        rd_now(8'h10, d); chk("R8 fault flag", d, 1);

        // R7: launch to a running channel 5
        ch_stopped = 8'hDF;
        stage(32'h05A0_0000, 32'h0000_2000);
        wr(8'h04, 0);
        wait_idle();
        rd_now(8'h14, d); chk("R7 launch error", d, 32'h11);
        ch_stopped = 8'hFF;

        // R10: a later good launch keeps fault bits
        stage(32'h01A0_0000, 32'hCAFE_0004);
        exp_q.push_back('{1, 32'hCAFE_0004, 1'b0});
        wr(8'h04, 0);
        wait_idle();
        rd_now(8'h14, d); chk("R10 fault sticky", d, 32'h11);

        // R1: reset clears faults
        do_reset();
        rd_now(8'h14, d); chk("R1 reset clears fault", d, 0);

        // R8: unknown manager opcode
        stage(32'h0055_0000, 0);
        wr(8'h04, 0);
        wait_idle();
        rd_now(8'h14, d); chk("R8 unknown opcode", d, 32'h01);

        // R9: channel field 9 on channel thread
        do_reset();
        stage(32'h0018_0901, 0);
        wr(8'h04, 0);
        wait_idle();
        rd_now(8'h14, d); chk("R9 bad chan field", d, 32'h01);

        // R9: launch opcode on channel thread is undefined, no start
        do_reset();
        stage(32'h01A0_0101, 32'h0000_4000);
        wr(8'h04, 0);
        wait_idle();
        rd_now(8'h14, d); chk("R9 chan launch undefined", d, 32'h01);

        repeat (4) @(negedge clk);
        chk("R4 scoreboard drained", 32'(exp_q.size()), 0);
        finished = 1;
        report();
    end
endmodule